// File: doc/BRIEF.md
# Automatic PoE Port Power Sequencer

This block runs the unattended power-up path of one Power over Ethernet port. Once the port is enabled, it probes the line for a valid signature at a low and a high probe level. It then reads the load's class current at the reduced classification voltage, ramps the port switch on, and watches the powered port for faults. The analog front end sits outside the block. The sequencer only selects the probe level, enables classification, enables the power ramp, and requests A/D conversions. In return it receives conversion results and comparator flags.

Discovery takes four samples in the order low, high, low, high. It accepts the port when the increase in current from each low sample to the high sample that follows stays inside a programmable window. Each fault source has its own rule. A current-cut or current-limit trip, or an undercurrent (dropout) condition, must persist for its own timer before the port is shut off. A voltage fault acts at once, but only while voltage monitoring is enabled. An over-temperature flag shuts the switch off at once. After any shut-off the port waits an error-delay period and then starts discovery again. All durations are parameters in clock ticks.

Top module: `poe_port_seq`

## Requirements
- R1: While rst_n is low at a clock edge, the port returns to state 0 (idle). After that edge probe_sel, class_en, ramp_en, adc_start, pgood, irq and class_o are all 0.
- R2: With enable high in idle, the port enters discovery (state 1) at the next edge. Discovery issues exactly four one-cycle adc_start pulses, with probe_sel reading 2'b01 (low level), 2'b10 (high level), 2'b01, 2'b10 at those pulses. Each pulse follows SETTLE_TICKS cycles of settling, and each sample is taken on the next adc_done. probe_sel is 2'b00 outside discovery.
- R3: Call the four discovery samples s0..s3. If s1-s0 and s3-s2 both lie within [DIFF_MIN, DIFF_MAX], the port moves to classification (state 2). Otherwise it moves to the error-delay state (state 5) without raising irq.
- R4: class_en is high only in state 2. Classification takes one conversion, and the result r is written to class_o. The code is 0 if r<CL1, 1 if r<CL2, 2 if r<CL3, 3 if r<CL4, 4 if r<CL_MAX, and 0 otherwise. class_o then holds until the next classification.
- R5: After classification the port spends exactly RAMP_TICKS cycles in state 3 with ramp_en high. It then enters state 4 (powered), where pgood and ramp_en are high.
- R6: While the port is powered, adc_start pulses for one cycle every MEAS_TICKS cycles.
- R7: cut_trip or lim_trip sampled high on CUT_TICKS consecutive edges in state 4 shuts the port off. A shorter burst has no effect.
- R8: low_i_trip sampled high on LOWI_TICKS consecutive edges in state 4 shuts the port off. A shorter burst has no effect.
- R9: uv_trip or ov_trip shuts a powered port off at the next edge only while vmon_en is high. With vmon_en low these flags have no effect.
- R10: hot_trip in state 3 or 4 shuts the port off at the next edge.
- R11: A shut-off takes the port to state 5 with ramp_en and pgood low and sets irq. irq stays set until irq_clr is sampled high, and a new fault in the same cycle wins over the clear.
- R12: The port stays in state 5 for exactly ERR_TICKS cycles and then restarts discovery (state 1).
- R13: enable sampled low in any state puts the port in idle (state 0) at the next edge, with all drives off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Port enable; low forces idle |
| vmon_en | input | 1 | Enables port voltage fault monitoring |
| irq_clr | input | 1 | Clears the sticky interrupt |
| adc_done | input | 1 | Conversion complete strobe |
| adc_result | input | ADC_W | Conversion result |
| cut_trip | input | 1 | Overcurrent cut comparator |
| lim_trip | input | 1 | Current limit comparator |
| low_i_trip | input | 1 | Load current below hold threshold |
| uv_trip | input | 1 | Port undervoltage flag |
| ov_trip | input | 1 | Port overvoltage flag |
| hot_trip | input | 1 | Over-temperature flag |
| state_o | output | 3 | Port state: 0 idle, 1 discovery, 2 class, 3 ramp, 4 powered, 5 error delay |
| probe_sel | output | 2 | Probe level: 00 off, 01 low, 10 high |
| class_en | output | 1 | Classification voltage enable |
| ramp_en | output | 1 | Power switch ramp/on enable |
| adc_start | output | 1 | One-cycle conversion request |
| class_o | output | 3 | Stored class code |
| pgood | output | 1 | Port powered |
| irq | output | 1 | Sticky fault interrupt |

## Verification
The state and every output are registered, so an effect is visible in the cycle after the edge that samples its cause. Voltage, over-temperature and enable take effect one cycle after the input changes. Current-cut and undercurrent faults take effect after exactly CUT_TICKS and LOWI_TICKS sampled edges, the ramp lasts RAMP_TICKS cycles and the error delay ERR_TICKS cycles. The bench changes inputs just after a falling edge and counts falling edges until the state moves, so each count equals the number of sampling edges and is compared with the parameter exactly. Bursts one edge shorter than a timer confirm that nothing moves. A scoreboard queue holds the expected state sequence, and every state change is popped and compared.

// File: rtl/poe_seq_pkg.sv
// Package: shared state, probe and phase encodings for the port sequencer.
// Assumes: state codes are visible at the port and must stay stable.
package poe_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_DISC  = 3'd1,
        ST_CLASS = 3'd2,
        ST_RAMP  = 3'd3,
        ST_ON    = 3'd4,
        ST_EDLY  = 3'd5
    } port_state_e;

    typedef enum logic [1:0] {
        PR_OFF  = 2'b00,
        PR_LOW  = 2'b01,
        PR_HIGH = 2'b10
    } probe_e;

    typedef enum logic {
        PH_SETTLE = 1'b0,
        PH_CONV   = 1'b1
    } meas_phase_e;

    localparam int unsigned DISC_POINTS = 4;

endpackage

// File: rtl/poe_tick_timer.sv
// Tick timer: counts consecutive cycles in which run is high and flags
// the cycle that completes LIMIT of them, then wraps to zero.
// Assumes: LIMIT >= 1; dropping run clears the count.
module poe_tick_timer #(
    parameter int unsigned LIMIT = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic hit
);
    localparam int unsigned CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

    logic [CW-1:0] cnt_q;

    assign hit = run && (cnt_q == CW'(LIMIT - 1));

    // Count run cycles; restart on release or on completion.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || hit) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/poe_sig_judge.sv
// Signature judge: checks that both low-to-high sample pairs rise by an
// amount inside [DIFF_MIN, DIFF_MAX].
// Assumes: samples are unsigned; a falling pair is invalid.
module poe_sig_judge #(
    parameter int unsigned W        = 12,
    parameter int unsigned DIFF_MIN = 40,
    parameter int unsigned DIFF_MAX = 120
) (
    input  logic [W-1:0] s0,
    input  logic [W-1:0] s1,
    input  logic [W-1:0] s2,
    input  logic [W-1:0] s3,
    output logic         valid
);
    localparam logic [W-1:0] LO_V = W'(DIFF_MIN);
    localparam logic [W-1:0] HI_V = W'(DIFF_MAX);

    logic [W-1:0] lo_s [2];
    logic [W-1:0] hi_s [2];
    logic [1:0]   ok;

    assign lo_s[0] = s0;
    assign hi_s[0] = s1;
    assign lo_s[1] = s2;
    assign hi_s[1] = s3;

    for (genvar g = 0; g < 2; g++) begin : g_pair
        logic [W-1:0] delta;
        assign delta = hi_s[g] - lo_s[g];
        assign ok[g] = (hi_s[g] >= lo_s[g]) && (delta >= LO_V) && (delta <= HI_V);
    end

    assign valid = &ok;
endmodule

// File: rtl/poe_class_map.sv
// Class map: converts a classification current sample into a class code
// by comparing it against ascending bounds.
// Assumes: CL1 < CL2 < CL3 < CL4 < CL_MAX; above CL_MAX maps to class 0.
module poe_class_map #(
    parameter int unsigned W      = 12,
    parameter int unsigned CL1    = 5,
    parameter int unsigned CL2    = 13,
    parameter int unsigned CL3    = 21,
    parameter int unsigned CL4    = 31,
    parameter int unsigned CL_MAX = 45
) (
    input  logic [W-1:0] sample,
    output logic [2:0]   code
);
    localparam int unsigned NB = 5;
    localparam int unsigned BOUND [NB] = '{CL1, CL2, CL3, CL4, CL_MAX};

    // Count how many bounds the sample reaches; top bucket is invalid.
    always_comb begin
        logic [2:0] above;
        above = '0;
        for (int i = 0; i < NB; i++) begin
            if (sample >= W'(BOUND[i])) begin
                above = above + 3'd1;
            end
        end
        code = (above == 3'(NB)) ? 3'd0 : above;
    end
endmodule

// File: rtl/poe_port_seq.sv
// Port sequencer top: runs discovery (four samples at two probe levels),
// classification, power ramp and powered monitoring, and handles fault
// shut-off, error delay and retry for one PoE port.
// Assumes: adc_done is a one-cycle strobe that follows adc_start; results
// arriving outside a conversion wait are ignored.
module poe_port_seq
    import poe_seq_pkg::*;
#(
    parameter int unsigned ADC_W        = 12,
    parameter int unsigned SETTLE_TICKS = 500000,
    parameter int unsigned RAMP_TICKS   = 62500,
    parameter int unsigned MEAS_TICKS   = 37500000,
    parameter int unsigned CUT_TICKS    = 7500000,
    parameter int unsigned LOWI_TICKS   = 40000000,
    parameter int unsigned ERR_TICKS    = 95000000,
    parameter int unsigned DIFF_MIN     = 40,
    parameter int unsigned DIFF_MAX     = 120,
    parameter int unsigned CL1          = 5,
    parameter int unsigned CL2          = 13,
    parameter int unsigned CL3          = 21,
    parameter int unsigned CL4          = 31,
    parameter int unsigned CL_MAX       = 45
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             vmon_en,
    input  logic             irq_clr,
    input  logic             adc_done,
    input  logic [ADC_W-1:0] adc_result,
    input  logic             cut_trip,
    input  logic             lim_trip,
    input  logic             low_i_trip,
    input  logic             uv_trip,
    input  logic             ov_trip,
    input  logic             hot_trip,
    output logic [2:0]       state_o,
    output logic [1:0]       probe_sel,
    output logic             class_en,
    output logic             ramp_en,
    output logic             adc_start,
    output logic [2:0]       class_o,
    output logic             pgood,
    output logic             irq
);
    localparam int unsigned PTW  = $clog2(DISC_POINTS);
    localparam logic [PTW-1:0] LAST_PT = PTW'(DISC_POINTS - 1);

    port_state_e  state_q, state_d;
    meas_phase_e  phase_q, phase_d;
    logic [PTW-1:0] pt_q, pt_d;
    logic [ADC_W-1:0] samp_q [DISC_POINTS-1];
    logic [2:0]   class_q;
    logic         irq_q;
    logic         start_q;

    logic settle_run, settle_hit;
    logic ramp_hit, edly_hit, meas_hit, cut_hit, lowi_hit;
    logic sig_ok;
    logic [2:0] class_code;
    logic vfault, fault_on, fault_ramp, fault_any;
    logic conv_end;

    // Timers for settling, ramp, error delay, periodic sampling and faults.
    assign settle_run = ((state_q == ST_DISC) || (state_q == ST_CLASS)) && (phase_q == PH_SETTLE);

    poe_tick_timer #(.LIMIT(SETTLE_TICKS)) i_settle (
        .clk(clk), .rst_n(rst_n), .run(settle_run), .hit(settle_hit));
    poe_tick_timer #(.LIMIT(RAMP_TICKS)) i_ramp (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_RAMP), .hit(ramp_hit));
    poe_tick_timer #(.LIMIT(ERR_TICKS)) i_edly (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_EDLY), .hit(edly_hit));
    poe_tick_timer #(.LIMIT(MEAS_TICKS)) i_meas (
        .clk(clk), .rst_n(rst_n), .run(state_q == ST_ON), .hit(meas_hit));
    poe_tick_timer #(.LIMIT(CUT_TICKS)) i_cut (
        .clk(clk), .rst_n(rst_n), .run((state_q == ST_ON) && (cut_trip || lim_trip)), .hit(cut_hit));
    poe_tick_timer #(.LIMIT(LOWI_TICKS)) i_lowi (
        .clk(clk), .rst_n(rst_n), .run((state_q == ST_ON) && low_i_trip), .hit(lowi_hit));

    poe_sig_judge #(.W(ADC_W), .DIFF_MIN(DIFF_MIN), .DIFF_MAX(DIFF_MAX)) i_judge (
        .s0(samp_q[0]), .s1(samp_q[1]), .s2(samp_q[2]), .s3(adc_result), .valid(sig_ok));

    poe_class_map #(.W(ADC_W), .CL1(CL1), .CL2(CL2), .CL3(CL3), .CL4(CL4), .CL_MAX(CL_MAX)) i_cmap (
        .sample(adc_result), .code(class_code));

    // Fault qualification per state.
    assign vfault     = vmon_en && (uv_trip || ov_trip);
    assign fault_on   = (state_q == ST_ON) && (cut_hit || lowi_hit || vfault || hot_trip);
    assign fault_ramp = (state_q == ST_RAMP) && hot_trip;
    assign fault_any  = enable && (fault_on || fault_ramp);
    assign conv_end   = (phase_q == PH_CONV) && adc_done;

    // Next-state selection for the port sequence.
    always_comb begin
        state_d = state_q;
        phase_d = phase_q;
        pt_d    = pt_q;
        unique case (state_q)
            ST_IDLE: begin
                state_d = ST_DISC;
                phase_d = PH_SETTLE;
                pt_d    = '0;
            end
            ST_DISC: begin
                if (settle_hit) begin
                    phase_d = PH_CONV;
                end else if (conv_end) begin
                    phase_d = PH_SETTLE;
                    if (pt_q != LAST_PT) begin
                        pt_d = pt_q + 1'b1;
                    end else begin
                        pt_d    = '0;
                        state_d = sig_ok ? ST_CLASS : ST_EDLY;
                    end
                end
            end
            ST_CLASS: begin
                if (settle_hit) begin
                    phase_d = PH_CONV;
                end else if (conv_end) begin
                    phase_d = PH_SETTLE;
                    state_d = ST_RAMP;
                end
            end
            ST_RAMP: begin
                if (fault_ramp) begin
                    state_d = ST_EDLY;
                end else if (ramp_hit) begin
                    state_d = ST_ON;
                end
            end
            ST_ON: begin
                if (fault_on) begin
                    state_d = ST_EDLY;
                end
            end
            ST_EDLY: begin
                if (edly_hit) begin
                    state_d = ST_DISC;
                    phase_d = PH_SETTLE;
                    pt_d    = '0;
                end
            end
            default: state_d = ST_IDLE;
        endcase
        if (!enable) begin
            state_d = ST_IDLE;
            phase_d = PH_SETTLE;
            pt_d    = '0;
        end
    end

    // Sequence registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            phase_q <= PH_SETTLE;
            pt_q    <= '0;
        end else begin
            state_q <= state_d;
            phase_q <= phase_d;
            pt_q    <= pt_d;
        end
    end

    // Capture the first three discovery samples; the fourth is judged live.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DISC_POINTS - 1; i++) begin
                samp_q[i] <= '0;
            end
        end else if ((state_q == ST_DISC) && conv_end && (pt_q != LAST_PT)) begin
            samp_q[pt_q] <= adc_result;
        end
    end

    // Store the class code at the end of the classification conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            class_q <= '0;
        end else if (enable && (state_q == ST_CLASS) && conv_end) begin
            class_q <= class_code;
        end
    end

    // Sticky interrupt: a new fault wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (fault_any) begin
            irq_q <= 1'b1;
        end else if (irq_clr) begin
            irq_q <= 1'b0;
        end
    end

    // One-cycle conversion request after settling or on the sampling period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
        end else begin
            start_q <= enable && (settle_hit || meas_hit);
        end
    end

    assign state_o   = state_q;
    assign probe_sel = (state_q != ST_DISC) ? PR_OFF : (pt_q[0] ? PR_HIGH : PR_LOW);
    assign class_en  = (state_q == ST_CLASS);
    assign ramp_en   = (state_q == ST_RAMP) || (state_q == ST_ON);
    assign pgood     = (state_q == ST_ON);
    assign adc_start = start_q;
    assign class_o   = class_q;
    assign irq       = irq_q;
endmodule

// File: rtl/poe_port_seq_chk.sv
// Checker: temporal properties of the port sequencer, bound to the top.
// Assumes: port names identical to the top module.
module poe_port_seq_chk #(
    parameter int unsigned ADC_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             enable,
    input logic             vmon_en,
    input logic             irq_clr,
    input logic             adc_done,
    input logic [ADC_W-1:0] adc_result,
    input logic             cut_trip,
    input logic             lim_trip,
    input logic             low_i_trip,
    input logic             uv_trip,
    input logic             ov_trip,
    input logic             hot_trip,
    input logic [2:0]       state_o,
    input logic [1:0]       probe_sel,
    input logic             class_en,
    input logic             ramp_en,
    input logic             adc_start,
    input logic [2:0]       class_o,
    input logic             pgood,
    input logic             irq
);
    AST_RESET_STATE: assert property (@(posedge clk)
        !rst_n |=> (state_o == 3'd0 && !pgood && !irq && !ramp_en && !adc_start && class_o == 3'd0)); // R1

    AST_DRIVE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({probe_sel, class_en, ramp_en})); // R2

    AST_PGOOD_AFTER_RAMP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pgood) |-> $past(state_o) == 3'd3); // R5

    AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start); // R6

    AST_VMON_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4 && enable && !vmon_en && !hot_trip && !cut_trip && !lim_trip && !low_i_trip)
        |=> state_o == 3'd4); // R9

    AST_HOT_CUTOFF: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && hot_trip && ramp_en) |=> !ramp_en); // R10

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !irq_clr) |=> irq); // R11

    AST_FAULT_FLAGS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (state_o == 3'd4) |=> (state_o != 3'd5 || irq)); // R11

    AST_DISABLE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> (state_o == 3'd0 && !ramp_en)); // R13
endmodule

bind poe_port_seq poe_port_seq_chk #(.ADC_W(ADC_W)) i_chk (.*);

// File: tb/test_poe_port_seq.sv
// Bench: scoreboard of expected state changes plus timed port checks.
module test_poe_port_seq;
    localparam int W      = 12;
    localparam int SETTLE = 4;
    localparam int RAMP   = 10;
    localparam int MEAS   = 20;
    localparam int CUT    = 6;
    localparam int LOWI   = 8;
    localparam int ERR    = 12;
    localparam int LAT    = 3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic enable = 1'b0, vmon_en = 1'b0, irq_clr = 1'b0, adc_done = 1'b0;
    logic [W-1:0] adc_result = '0;
    logic cut_trip = 1'b0, lim_trip = 1'b0, low_i_trip = 1'b0;
    logic uv_trip = 1'b0, ov_trip = 1'b0, hot_trip = 1'b0;
    logic [2:0] state_o, class_o;
    logic [1:0] probe_sel;
    logic class_en, ramp_en, adc_start, pgood, irq;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;
    int v_low = 100, v_high = 180, v_class = 15;
    int exp_q[$];
    logic [2:0] last_state = 3'd0;

    always #4 clk = ~clk;

    poe_port_seq #(
        .ADC_W(W), .SETTLE_TICKS(SETTLE), .RAMP_TICKS(RAMP), .MEAS_TICKS(MEAS),
        .CUT_TICKS(CUT), .LOWI_TICKS(LOWI), .ERR_TICKS(ERR),
        .DIFF_MIN(40), .DIFF_MAX(120),
        .CL1(5), .CL2(13), .CL3(21), .CL4(31), .CL_MAX(45)
    ) i_poe_port_seq (
        .clk(clk), .rst_n(rst_n), .enable(enable), .vmon_en(vmon_en), .irq_clr(irq_clr),
        .adc_done(adc_done), .adc_result(adc_result),
        .cut_trip(cut_trip), .lim_trip(lim_trip), .low_i_trip(low_i_trip),
        .uv_trip(uv_trip), .ov_trip(ov_trip), .hot_trip(hot_trip),
        .state_o(state_o), .probe_sel(probe_sel), .class_en(class_en), .ramp_en(ramp_en),
        .adc_start(adc_start), .class_o(class_o), .pgood(pgood), .irq(irq));

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic push(input int s);
        exp_q.push_back(s);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    task automatic wait_state(input int s);
        while (state_o != 3'(s)) @(negedge clk);
    endtask

    // Counts falling edges until the state leaves s (including the current one).
    task automatic dwell(input int s, output int n);
        n = 0;
        while (state_o == 3'(s)) begin
            n++;
            @(negedge clk);
        end
    endtask

    // Counts falling edges after a stimulus until the state becomes s.
    task automatic lag(input int s, output int n);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (state_o != 3'(s) && n < 100);
    endtask

    // Monitor: every state change is popped from the expected queue.
    always @(negedge clk) begin
        if (rst_n && state_o != last_state) begin
            if (exp_q.size() == 0) begin
                chk("R2 scoreboard unexpected state", int'(state_o), -1);
            end else begin
                chk("R3/R12 scoreboard state sequence", int'(state_o), exp_q.pop_front());
            end
            last_state = state_o;
        end
    end

    // Front-end model: answers each conversion request after LAT cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (adc_start) begin
                repeat (LAT) @(negedge clk);
                if (class_en) adc_result = W'(v_class);
                else if (probe_sel == 2'b10) adc_result = W'(v_high);
                else adc_result = W'(v_low);
                adc_done = 1'b1;
                @(negedge clk);
                adc_done = 1'b0;
            end
        end
    end

    // Watchdog.
    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int n;
        int probes[4];
        int np;
        bit cls_seen;
        bit cls_stray;

        // R1: reset state.
        repeat (5) @(negedge clk);
        chk("R1 state", state_o, 0);
        chk("R1 ramp_en", ramp_en, 0);
        chk("R1 adc_start", adc_start, 0);
        chk("R1 pgood/irq", {pgood, irq}, 0);
        chk("R1 class_o", class_o, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R13 idle while disabled", state_o, 0);
        chk("R2 probe off in idle", probe_sel, 0);

        // R2-R5: first power-up, class 2.
        push(1); push(2); push(3); push(4);
        enable = 1'b1;
        np = 0; cls_seen = 0; cls_stray = 0;
        @(negedge clk);
        chk("R2 discovery entered", state_o, 1);
        while (state_o != 3'd3) begin
            if (adc_start && state_o == 3'd1 && np < 4) begin
                probes[np] = int'(probe_sel);
                np++;
            end
            if (class_en && state_o == 3'd2) cls_seen = 1;
            if (class_en && state_o != 3'd2) cls_stray = 1;
            @(negedge clk);
        end
        chk("R2 discovery sample count", np, 4);
        chk("R2 probe order", probes[0]*1000 + probes[1]*100 + probes[2]*10 + probes[3], 1212);
        chk("R4 class_en in class state", cls_seen, 1);
        chk("R4 class_en only in class state", cls_stray, 0);
        chk("R5 ramp_en during ramp", ramp_en, 1);
        dwell(3, n);
        chk("R5 ramp length", n, RAMP);
        chk("R5 pgood when powered", pgood, 1);
        chk("R4 class code 2", class_o, 2);

        // R6: periodic sampling.
        while (!adc_start) @(negedge clk);
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!adc_start);
        chk("R6 sampling period", n, MEAS);

        // R7: short burst ignored, full burst shuts off.
        cut_trip = 1'b1;
        repeat (CUT - 1) @(negedge clk);
        cut_trip = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 short overcurrent ignored", state_o, 4);
        chk("R7 no irq from short burst", irq, 0);
        push(5); push(1); push(2); push(3); push(4);
        v_class = 40;
        lim_trip = 1'b1;
        lag(5, n);
        lim_trip = 1'b0;
        chk("R7 current fault delay", n, CUT);
        chk("R11 irq set", irq, 1);
        chk("R11 power off", {ramp_en, pgood}, 0);
        dwell(5, n);
        chk("R12 error delay length", n, ERR);
        chk("R12 rediscovery", state_o, 1);
        chk("R11 irq sticky", irq, 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        chk("R11 irq cleared", irq, 0);
        wait_state(4);
        chk("R4 class code 4", class_o, 4);

        // R8: undercurrent dropout.
        low_i_trip = 1'b1;
        repeat (LOWI - 1) @(negedge clk);
        low_i_trip = 1'b0;
        repeat (2) @(negedge clk);
        chk("R8 short dropout ignored", state_o, 4);
        push(5); push(1); push(2); push(3);
        v_class = 60;
        low_i_trip = 1'b1;
        lag(5, n);
        low_i_trip = 1'b0;
        chk("R8 dropout delay", n, LOWI);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;

        // R10: over-temperature during ramp.
        wait_state(3);
        push(5); push(1); push(2); push(3); push(4);
        hot_trip = 1'b1;
        lag(5, n);
        hot_trip = 1'b0;
        chk("R10 hot cut in ramp", n, 1);
        chk("R10 ramp_en off", ramp_en, 0);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;
        wait_state(4);
        chk("R4 class code above max is 0", class_o, 0);

        // R9: voltage flags masked, then active.
        uv_trip = 1'b1;
        repeat (10) @(negedge clk);
        chk("R9 masked voltage fault state", state_o, 4);
        chk("R9 masked voltage fault irq", irq, 0);
        uv_trip = 1'b0;
        vmon_en = 1'b1;
        push(5); push(1); push(2); push(3); push(4);
        ov_trip = 1'b1;
        lag(5, n);
        ov_trip = 1'b0;
        vmon_en = 1'b0;
        chk("R9 voltage fault delay", n, 1);

        // R11: fault and clear in the same cycle, fault wins.
        wait_state(4);
        v_high = 110;
        push(5); push(1); push(5); push(0);
        hot_trip = 1'b1;
        irq_clr = 1'b1;
        lag(5, n);
        hot_trip = 1'b0;
        irq_clr = 1'b0;
        chk("R10 hot cut when powered", n, 1);
        chk("R11 fault wins over clear", irq, 1);
        irq_clr = 1'b1;
        @(negedge clk);
        irq_clr = 1'b0;

        // R3: bad signature goes to error delay without irq.
        wait_state(1);
        wait_state(5);
        chk("R3 rejected signature no irq", irq, 0);
        chk("R3 no power on rejection", ramp_en, 0);

        // R13: disable from error delay.
        enable = 1'b0;
        @(negedge clk);
        chk("R13 idle after disable", state_o, 0);
        chk("R13 drives off", {probe_sel, class_en, ramp_en, pgood}, 0);
        repeat (ERR + 5) @(negedge clk);
        chk("R13 stays idle", state_o, 0);
        chk("R2 scoreboard drained", exp_q.size(), 0);
        finish_run();
    end
endmodule